// File: doc/BRIEF.md
# DCO Loop Filter with Sigma-Delta Dither

This block is the digital loop filter of an all-digital PLL. It turns error words from two detectors into the control words of a digitally controlled oscillator. While acquiring, a low-resolution frequency error steers a coarse bank code one step at a time. Once that error has stayed near zero for a programmable run of reference periods, the coarse code is frozen and control moves to a high-resolution phase path.

The phase path drives a proportional-integral update. The gains are expressed as arithmetic right shifts, and the update happens only in reference periods in which the phase detector strobes a new word. The resulting fine control word is unsigned and saturating. Its upper bits drive the fine bank. Its lower 8 bits are a fraction fed to a first-order sigma-delta accumulator, which runs on a separate, faster divided-oscillator clock. The accumulator's carry dithers the oscillator's least significant control bit, so the average code has fractional resolution.

Top module: `dco_loop_filter`

## Requirements
- R1: After reset: coarse_code_o is midscale (32), the fine word is midscale (8192, so fine_code_o = 32 and the fraction is 0), fine_mode_o is 0, and dither_o is 0.
- R2: In coarse mode, each freq_vld_i strobe moves coarse_code_o at the clock edge that samples it. A signed freq_err_i greater than +1 moves it up by one, an error less than -1 moves it down by one, and an error in [-1,+1] leaves it unchanged. The code saturates at 0 and 63 and does not wrap.
- R3: In-window strobes (freq_err_i in [-1,+1]) are counted. Cycles without a strobe keep the count, and an out-of-window strobe clears it. On the strobe that brings the count to lock_len_i, fine_mode_o rises at that edge. A lock_len_i of 0 acts as 1. fine_mode_o then stays high until reset.
- R4: In fine mode, freq_vld_i and freq_err_i have no effect on coarse_code_o.
- R5: In coarse mode, phase strobes have no effect on the fine word.
- R6: In fine mode, a phase_vld_i strobe with signed error e updates the integrator first: I = clamp(I + (e >>> beta_shift_i)). The fine word is then W = clamp(I + (e >>> alpha_shift_i)). Both use arithmetic shifts 0..15, and the clamp range is [0, 16383]. fine_code_o = W[13:8] from the same edge.
- R7: In a cycle without phase_vld_i, the integrator and the fine word hold, whatever phase_err_i carries.
- R8: The integrator and the fine word saturate at 0 and 16383 instead of wrapping.
- R9: With the fraction W[7:0] held constant, dither_o (on dsm_clk_i) is 1 in exactly W[7:0] of any 256 consecutive dsm_clk_i cycles, once a few cycles have passed for the fraction to cross clock domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| dsm_clk_i | input | 1 | Divided oscillator clock for the dither accumulator |
| freq_err_i | input | 8 | Signed coarse frequency error |
| freq_vld_i | input | 1 | Frequency error strobe |
| phase_err_i | input | 8 | Signed fine phase error |
| phase_vld_i | input | 1 | Phase error strobe |
| alpha_shift_i | input | 4 | Proportional gain shift |
| beta_shift_i | input | 4 | Integral gain shift |
| lock_len_i | input | 8 | In-window strobes needed to enter fine mode |
| coarse_code_o | output | 6 | Coarse bank code |
| fine_code_o | output | 6 | Fine bank code (integer part of fine word) |
| dither_o | output | 1 | Sigma-delta dither for the oscillator LSB |
| fine_mode_o | output | 1 | High once the coarse code is frozen |

## Verification
Integrator saturation is the hardest case to reach from the ports. It lies behind the coarse lock, and only 6 of the 14 word bits are visible. The stimulus first walks the coarse code to both rails and back, then builds an exact lock run broken once by an outlier. With both shifts at zero it then drives full-scale phase errors until the word pins at the top, and applies a single small opposite error that would expose a wrapped integrator on fine_code_o. The fraction is observed only through dither density, counted over 256 dither-clock cycles at several word values, including 0 and 255.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic {
    ACQ_COARSE = 1'b0,
    ACQ_FINE   = 1'b1
  } acq_mode_e;
endpackage

// File: rtl/lf_coarse_acq.sv
module lf_coarse_acq #(
  parameter int ERR_W  = 8,
  parameter int CODE_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ERR_W-1:0]  freq_err_i,
  input  logic              freq_vld_i,
  input  logic [CNT_W-1:0]  lock_len_i,
  output logic [CODE_W-1:0] coarse_code_o,
  output logic              fine_mode_o
);
  import lf_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic signed [ERR_W-1:0] PLUS_ONE  = ERR_W'(1);
  localparam logic signed [ERR_W-1:0] MINUS_ONE = '1;

  acq_mode_e         mode_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q, cnt_inc, len_eff;
  logic signed [ERR_W-1:0] err_s;
  logic              err_hi, err_lo, strobe;

  assign err_s   = $signed(freq_err_i);
  assign err_hi  = err_s > PLUS_ONE;
  assign err_lo  = err_s < MINUS_ONE;
  assign strobe  = freq_vld_i && (mode_q == ACQ_COARSE);
  assign len_eff = (lock_len_i == '0) ? CNT_W'(1) : lock_len_i;
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ACQ_COARSE;
      code_q <= CODE_MID;
      cnt_q  <= '0;
    end else if (strobe) begin
      if (err_hi) begin
        cnt_q <= '0;
        if (code_q != '1) code_q <= code_q + CODE_W'(1);
      end else if (err_lo) begin
        cnt_q <= '0;
        if (code_q != '0) code_q <= code_q - CODE_W'(1);
      end else begin
        cnt_q <= cnt_inc;
        if (cnt_inc >= len_eff) mode_q <= ACQ_FINE;
      end
    end
  end

  assign coarse_code_o = code_q;
  assign fine_mode_o   = (mode_q == ACQ_FINE);

  // R2/R4: the code moves only after a strobe seen in coarse mode
  p_code_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> ($past(freq_vld_i) && ($past(mode_q) == ACQ_COARSE)));

  // R3: fine mode is sticky
  p_mode_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == ACQ_FINE) |-> (mode_q == ACQ_FINE));

  // R3: entry into fine mode needs an in-window strobe
  p_lock_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fine_mode_o) |-> ($past(freq_vld_i) && !$past(err_hi) && !$past(err_lo)));

  // R2: one step per strobe at most
  p_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q > $past(code_q)) |-> (code_q == $past(code_q) + CODE_W'(1)));
endmodule

// File: rtl/lf_pi_core.sv
module lf_pi_core #(
  parameter int ERR_W   = 8,
  parameter int WORD_W  = 14,
  parameter int SHIFT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [ERR_W-1:0]   phase_err_i,
  input  logic               phase_vld_i,
  input  logic [SHIFT_W-1:0] alpha_shift_i,
  input  logic [SHIFT_W-1:0] beta_shift_i,
  output logic [WORD_W-1:0]  word_o
);
  localparam int EXT_W = WORD_W + 2;
  localparam logic [WORD_W-1:0] WORD_MID = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] MAX_S = $signed({2'b00, {WORD_W{1'b1}}});

  logic [WORD_W-1:0] integ_q, word_q, integ_d, word_d;
  logic signed [EXT_W-1:0] err_ext, p_term, i_term, integ_sum, word_sum;
  logic upd;

  function automatic logic [WORD_W-1:0] clamp(input logic signed [EXT_W-1:0] v);
    if (v[EXT_W-1])      return '0;
    else if (v > MAX_S)  return '1;
    else                 return v[WORD_W-1:0];
  endfunction

  assign upd       = en_i && phase_vld_i;
  assign err_ext   = $signed({{(EXT_W-ERR_W){phase_err_i[ERR_W-1]}}, phase_err_i});
  assign p_term    = err_ext >>> alpha_shift_i;
  assign i_term    = err_ext >>> beta_shift_i;
  assign integ_sum = $signed({2'b00, integ_q}) + i_term;
  assign integ_d   = clamp(integ_sum);
  assign word_sum  = $signed({2'b00, integ_d}) + p_term;
  assign word_d    = clamp(word_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= WORD_MID;
      word_q  <= WORD_MID;
    end else if (upd) begin
      integ_q <= integ_d;
      word_q  <= word_d;
    end
  end

  assign word_o = word_q;

  // R7: no strobe, no change
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(upd) |-> ($stable(word_q) && $stable(integ_q)));

  // R5: coarse mode leaves the word alone
  p_coarse_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(word_q));

  // R8: a positive error never lowers the word below the old integrator
  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd) && !$past(err_ext[EXT_W-1])) |-> (word_q >= $past(integ_q)));

  // R8: a negative error never raises the word above the old integrator
  p_no_wrap_neg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd) && $past(err_ext[EXT_W-1])) |-> (word_q <= $past(integ_q)));
endmodule

// File: rtl/lf_sd_dither.sv
module lf_sd_dither #(
  parameter int FRAC_W      = 8,
  parameter int SYNC_STAGES = 3
) (
  input  logic              dsm_clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              dither_o
);
  logic [FRAC_W-1:0] sync_q [SYNC_STAGES];
  logic [FRAC_W-1:0] frac_q, acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              dither_q;

  always_ff @(posedge dsm_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= frac_i;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge dsm_clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[k] <= '0;
      else         sync_q[k] <= sync_q[k-1];
    end
  end

  // accept a multi-bit word only after it has been seen twice in a row
  always_ff @(posedge dsm_clk_i or negedge rst_ni) begin
    if (!rst_ni) frac_q <= '0;
    else if (sync_q[SYNC_STAGES-1] == sync_q[SYNC_STAGES-2]) frac_q <= sync_q[SYNC_STAGES-1];
  end

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_q};

  always_ff @(posedge dsm_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      dither_q <= 1'b0;
    end else begin
      acc_q    <= acc_sum[FRAC_W-1:0];
      dither_q <= acc_sum[FRAC_W];
    end
  end

  assign dither_o = dither_q;

  // R9: zero fraction gives no carry
  p_zero_frac_r9: assert property (@(posedge dsm_clk_i) disable iff (!rst_ni)
    (frac_q == '0) |=> !dither_q);

  // R9: carry implies the accumulator wrapped below its old value
  p_carry_wrap_r9: assert property (@(posedge dsm_clk_i) disable iff (!rst_ni)
    dither_q |-> (acc_q < $past(acc_q) || frac_q == '1 || $past(frac_q) == '1 || $past(frac_q) != frac_q || acc_q <= $past(acc_q)));
endmodule

// File: rtl/dco_loop_filter.sv
module dco_loop_filter #(
  parameter int FERR_W      = 8,
  parameter int PERR_W      = 8,
  parameter int COARSE_W    = 6,
  parameter int FINE_W      = 6,
  parameter int FRAC_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SHIFT_W     = 4,
  parameter int SYNC_STAGES = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dsm_clk_i,
  input  logic [FERR_W-1:0]   freq_err_i,
  input  logic                freq_vld_i,
  input  logic [PERR_W-1:0]   phase_err_i,
  input  logic                phase_vld_i,
  input  logic [SHIFT_W-1:0]  alpha_shift_i,
  input  logic [SHIFT_W-1:0]  beta_shift_i,
  input  logic [CNT_W-1:0]    lock_len_i,
  output logic [COARSE_W-1:0] coarse_code_o,
  output logic [FINE_W-1:0]   fine_code_o,
  output logic                dither_o,
  output logic                fine_mode_o
);
  localparam int WORD_W = FINE_W + FRAC_W;

  logic              fine_mode;
  logic [WORD_W-1:0] word;

  lf_coarse_acq #(
    .ERR_W (FERR_W),
    .CODE_W(COARSE_W),
    .CNT_W (CNT_W)
  ) u_acq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .freq_err_i   (freq_err_i),
    .freq_vld_i   (freq_vld_i),
    .lock_len_i   (lock_len_i),
    .coarse_code_o(coarse_code_o),
    .fine_mode_o  (fine_mode)
  );

  lf_pi_core #(
    .ERR_W  (PERR_W),
    .WORD_W (WORD_W),
    .SHIFT_W(SHIFT_W)
  ) u_pi (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (fine_mode),
    .phase_err_i  (phase_err_i),
    .phase_vld_i  (phase_vld_i),
    .alpha_shift_i(alpha_shift_i),
    .beta_shift_i (beta_shift_i),
    .word_o       (word)
  );

  lf_sd_dither #(
    .FRAC_W     (FRAC_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sd (
    .dsm_clk_i(dsm_clk_i),
    .rst_ni   (rst_ni),
    .frac_i   (word[FRAC_W-1:0]),
    .dither_o (dither_o)
  );

  assign fine_code_o = word[WORD_W-1:FRAC_W];
  assign fine_mode_o = fine_mode;

  // R1: reset values seen right after reset release
  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!fine_mode_o));
endmodule

// File: tb/sim_dco_loop_filter.sv
`timescale 1ns/100ps
module sim_dco_loop_filter;
  logic       clk = 1'b0, dsm_clk = 1'b0, rst_n = 1'b0;
  logic [7:0] freq_err = '0, phase_err = '0, lock_len = 8'd4;
  logic       freq_vld = 1'b0, phase_vld = 1'b0;
  logic [3:0] alpha = '0, beta = '0;
  logic [5:0] coarse_code, fine_code;
  logic       dither, fine_mode;

  int n_chk = 0, n_err = 0;
  int m_coarse, m_word, m_int, m_cnt;
  bit m_fine;

  always #2 clk = ~clk;
  initial begin
    #0.5;
    forever #1 dsm_clk = ~dsm_clk;
  end

  dco_loop_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .dsm_clk_i(dsm_clk),
    .freq_err_i(freq_err), .freq_vld_i(freq_vld),
    .phase_err_i(phase_err), .phase_vld_i(phase_vld),
    .alpha_shift_i(alpha), .beta_shift_i(beta), .lock_len_i(lock_len),
    .coarse_code_o(coarse_code), .fine_code_o(fine_code),
    .dither_o(dither), .fine_mode_o(fine_mode)
  );

  function automatic int clampw(int v);
    if (v < 0) return 0;
    if (v > 16383) return 16383;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_coarse = 32; m_word = 8192; m_int = 8192; m_cnt = 0; m_fine = 0;
  endtask

  task automatic cyc(int fe, bit fv, int pe, bit pv, string tag);
    int len;
    freq_err = fe[7:0]; freq_vld = fv; phase_err = pe[7:0]; phase_vld = pv;
    @(posedge clk);
    if (m_fine && pv) begin
      m_int  = clampw(m_int + (pe >>> int'(beta)));
      m_word = clampw(m_int + (pe >>> int'(alpha)));
    end
    if (!m_fine && fv) begin
      len = (lock_len == 0) ? 1 : int'(lock_len);
      if (fe > 1) begin
        m_cnt = 0; if (m_coarse < 63) m_coarse++;
      end else if (fe < -1) begin
        m_cnt = 0; if (m_coarse > 0) m_coarse--;
      end else begin
        if (m_cnt < 255) m_cnt++;
        if (m_cnt >= len) m_fine = 1;
      end
    end
    #1;
    check(tag, int'(coarse_code), m_coarse, "coarse_code");
    check(tag, int'(fine_code), m_word / 256, "fine_code");
    check(tag, int'(fine_mode), int'(m_fine), "fine_mode");
    @(negedge clk);
    freq_vld = 1'b0; phase_vld = 1'b0;
  endtask

  task automatic chk_dither(string tag);
    int ones = 0;
    repeat (6) @(negedge clk);
    repeat (256) begin
      @(negedge dsm_clk);
      ones += int'(dither);
    end
    check(tag, ones, m_word % 256, "dither ones in 256");
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int errs[8]   = '{-37, 64, -128, 127, 5, -1, 90, -3};
    int ashift[8] = '{2, 0, 3, 1, 0, 5, 4, 7};
    int bshift[8] = '{4, 3, 6, 2, 1, 0, 5, 7};
    do_reset();
    // R1: reset state
    cyc(0, 0, 0, 0, "R1");
    check("R1", int'(dither), 0, "dither");
    chk_dither("R1_R9");
    // R5: phase strobe ignored in coarse mode
    cyc(0, 0, 100, 1, "R5");
    cyc(0, 0, -100, 1, "R5");
    // R2: stepping and saturation of coarse code
    cyc(5, 1, 0, 0, "R2");
    cyc(2, 1, 0, 0, "R2");
    cyc(-7, 1, 0, 0, "R2");
    repeat (40) cyc(100, 1, 0, 0, "R2");
    repeat (70) cyc(-128, 1, 0, 0, "R2");
    repeat (10) cyc(3, 1, 0, 0, "R2");
    // R3: lock run broken once, idle cycles keep count
    cyc(0, 1, 0, 0, "R3");
    cyc(1, 1, 0, 0, "R3");
    cyc(5, 1, 0, 0, "R3");
    cyc(0, 1, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    cyc(-1, 1, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    cyc(1, 1, 0, 0, "R3");
    cyc(0, 1, 0, 0, "R3");
    check("R3", int'(fine_mode), 1, "fine_mode after 4 in-window");
    // R4: coarse frozen
    cyc(60, 1, 0, 0, "R4");
    cyc(-60, 1, 0, 0, "R4");
    // R6/R7: PI update and hold
    alpha = 4'd2; beta = 4'd4;
    cyc(0, 0, 100, 1, "R6");
    cyc(0, 0, -90, 0, "R7");
    cyc(0, 0, 127, 0, "R7");
    chk_dither("R9");
    for (int i = 0; i < 8; i++) begin
      alpha = 4'(ashift[i]); beta = 4'(bshift[i]);
      cyc(0, 0, errs[i], 1, "R6");
      cyc(0, 0, 0, 0, "R7");
    end
    chk_dither("R9");
    alpha = 4'd15; beta = 4'd15;
    cyc(0, 0, 127, 1, "R6");
    cyc(0, 0, -5, 1, "R6");
    chk_dither("R9");
    // R8: saturation at top, then no wrap on small step back
    alpha = 4'd0; beta = 4'd0;
    repeat (80) cyc(0, 0, 127, 1, "R8");
    check("R8", int'(fine_code), 63, "fine_code at top");
    chk_dither("R8_R9");
    cyc(0, 0, -1, 1, "R8");
    cyc(0, 0, 3, 1, "R8");
    repeat (150) cyc(0, 0, -128, 1, "R8");
    check("R8", int'(fine_code), 0, "fine_code at bottom");
    cyc(0, 0, 3, 1, "R8");
    chk_dither("R9");
    // R3: lock_len of zero acts as one
    lock_len = 8'd0;
    do_reset();
    cyc(0, 0, 0, 0, "R1");
    cyc(1, 1, 0, 0, "R3");
    check("R3", int'(fine_mode), 1, "fine_mode with len 0");
    cyc(0, 0, 40, 1, "R6");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule